// File: doc/BRIEF.md
# Lockable DMA Protected-Range Checker

This block keeps one protected window of upper physical memory, described by a start register and an end register, and decides for each incoming DMA address whether it may proceed. Software programs the window and a protection-enable bit through a small register port. Each window register keeps a writable field between two bit positions. The bits above and below that field read as zero. The bits below the field form the alignment granularity: the start address treats them as zero and the end address treats them as all ones. As a result the window always covers whole granules.

Two single-cycle command strobes freeze and release the window registers. A capability input can declare the feature absent, and the window registers then never accept writes. While protection is enabled the window is also frozen, so the window cannot move under live traffic. An end value below the start value switches the window off without any report. Address bits above the host address width take no part in the comparison.

Top module: `dma_prot_range`

## Requirements
- R1: After reset, reading the start register (sel 0), the end register (sel 1) and the control register (sel 2, bit 0 = enable) returns zero, and no request is blocked.
- R2: Register reads return bits 35:21 as written. Bits 63:36 and 20:0 read as zero, so writing all ones to the end register returns 0x0000_000F_FFE0_0000.
- R3: While the lock state is set, writes to start and end are ignored. A cmd_lock pulse sets the lock state, and a cmd_unlock pulse clears it.
- R4: When cmd_lock and cmd_unlock are both high in the same cycle, the block ends up locked.
- R5: When cap_supported is 0, writes to start and end are ignored.
- R6: While enable is 1, writes to start and end are ignored. Writes to the control register are always accepted.
- R7: An address is blocked when enable is 1, start ≤ end, and start ≤ addr[35:0] ≤ (end | 0x1FFFFF). The comparison uses start's bits 20:0 as zero.
- R8: When the programmed end is below the programmed start, no address is blocked.
- R9: Address bits 63:36 do not affect the result.
- R10: The req_valid output and the blocked output are registered. Both appear in the cycle after req_valid_in, and the result is held while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_supported | input | 1 | 1 when the protected window feature is present |
| cmd_lock | input | 1 | Lock pulse for the window registers |
| cmd_unlock | input | 1 | Unlock pulse for the window registers |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 start, 1 end, 2 control |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for reg_sel |
| req_valid_in | input | 1 | DMA request strobe |
| req_addr | input | 64 | DMA address |
| resp_valid | output | 1 | Result valid, one cycle after the request |
| resp_blocked | output | 1 | 1 when the request falls in the protected window |

## Verification
The hardest cases to reach from the ports are the ones at the exact granule edges: the last byte of the end granule, the byte after it, and the byte just below start. The bench sets the window with directed writes and then drives addresses at those edges, with random values in the upper address bits. It also issues random mixtures of lock and unlock pulses, enable toggles and writes, including cycles where both commands arrive together. A bench model tracks the state that the writes should leave behind.

// File: rtl/dma_prot_pkg.sv
package dma_prot_pkg;
  localparam int unsigned REG_W  = 64;
  localparam int unsigned HAW    = 36;
  localparam int unsigned GRAN_N = 20;
  localparam int unsigned FLD_LO = GRAN_N + 1;
  localparam int unsigned FLD_W  = HAW - FLD_LO;

  typedef enum logic [1:0] {SEL_BASE = 2'd0, SEL_LIMIT = 2'd1, SEL_CTRL = 2'd2} sel_e;

  function automatic logic [HAW-1:0] base_expand(input logic [FLD_W-1:0] f);
    return {f, {FLD_LO{1'b0}}};
  endfunction

  function automatic logic [HAW-1:0] limit_expand(input logic [FLD_W-1:0] f);
    return {f, {FLD_LO{1'b1}}};
  endfunction

  function automatic logic [REG_W-1:0] reg_view(input logic [FLD_W-1:0] f);
    return {{(REG_W-HAW){1'b0}}, f, {FLD_LO{1'b0}}};
  endfunction
endpackage

// File: rtl/dma_prot_lock.sv
module dma_prot_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_lock,
  input  logic cmd_unlock,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)          locked <= 1'b0;
    else if (cmd_lock)   locked <= 1'b1;
    else if (cmd_unlock) locked <= 1'b0;
  end

  p_lock_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lock && cmd_unlock) |=> locked);
  p_unlock_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_unlock && !cmd_lock) |=> !locked);
endmodule

// File: rtl/dma_prot_regs.sv
module dma_prot_regs
  import dma_prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_supported,
  input  logic             locked,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [FLD_W-1:0] base_f,
  output logic [FLD_W-1:0] limit_f,
  output logic             enable
);
  logic range_wr_ok;
  logic base_we, limit_we;
  assign range_wr_ok = cap_supported && !locked && !enable;
  assign base_we  = reg_wr && (reg_sel == SEL_BASE)  && range_wr_ok;
  assign limit_we = reg_wr && (reg_sel == SEL_LIMIT) && range_wr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_f  <= '0;
      limit_f <= '0;
      enable  <= 1'b0;
    end else begin
      if (base_we)  base_f  <= reg_wdata[HAW-1:FLD_LO];
      if (limit_we) limit_f <= reg_wdata[HAW-1:FLD_LO];
      if (reg_wr && reg_sel == SEL_CTRL) enable <= reg_wdata[0];
    end
  end

  always_comb begin
    unique case (reg_sel)
      SEL_BASE:  reg_rdata = reg_view(base_f);
      SEL_LIMIT: reg_rdata = reg_view(limit_f);
      SEL_CTRL:  reg_rdata = {{(REG_W-1){1'b0}}, enable};
      default:   reg_rdata = '0;
    endcase
  end

  p_lock_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(base_f) && $stable(limit_f)));
  p_nocap_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_supported |=> ($stable(base_f) && $stable(limit_f)));
  p_enable_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(base_f) && $stable(limit_f)));
  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:HAW] == '0);
endmodule

// File: rtl/dma_prot_cmp.sv
module dma_prot_cmp
  import dma_prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [FLD_W-1:0] base_f,
  input  logic [FLD_W-1:0] limit_f,
  input  logic             req_valid_in,
  input  logic [REG_W-1:0] req_addr,
  output logic             resp_valid,
  output logic             resp_blocked
);
  logic [HAW-1:0] lo_addr, hi_addr, a;
  logic region_valid, in_range, hit;
  assign lo_addr      = base_expand(base_f);
  assign hi_addr      = limit_expand(limit_f);
  assign a            = req_addr[HAW-1:0];
  assign region_valid = limit_f >= base_f;
  assign in_range     = (a >= lo_addr) && (a <= hi_addr);
  assign hit          = enable && region_valid && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_blocked <= 1'b0;
    end else begin
      resp_valid <= req_valid_in;
      if (req_valid_in) resp_blocked <= hit;
    end
  end

  p_invalid_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_in && !region_valid) |=> !resp_blocked);
  p_disabled_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_in && !enable) |=> !resp_blocked);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_in |=> $stable(resp_blocked));
endmodule

// File: rtl/dma_prot_range.sv
module dma_prot_range
  import dma_prot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_supported,
  input  logic             cmd_lock,
  input  logic             cmd_unlock,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             req_valid_in,
  input  logic [REG_W-1:0] req_addr,
  output logic             resp_valid,
  output logic             resp_blocked
);
  logic             locked, enable;
  logic [FLD_W-1:0] base_f, limit_f;

  dma_prot_lock u_lock (
    .clk(clk), .rst_n(rst_n), .cmd_lock(cmd_lock), .cmd_unlock(cmd_unlock), .locked(locked));

  dma_prot_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cap_supported(cap_supported), .locked(locked),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .base_f(base_f), .limit_f(limit_f), .enable(enable));

  dma_prot_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_f(base_f), .limit_f(limit_f),
    .req_valid_in(req_valid_in), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_blocked(resp_blocked));

  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_in |=> resp_valid);
endmodule

// File: tb/tb_dma_prot_range.sv
module tb_dma_prot_range;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0, cap = 1, lk = 0, ulk = 0, wr = 0, rv = 0;
  logic [1:0] sel = 0;
  logic [63:0] wdata = 0, rdata, addr = 0;
  logic resp_valid, resp_blocked;
  int n_tests = 0, n_fail = 0;
  logic [14:0] m_base = 0, m_lim = 0;
  logic m_en = 0, m_lock = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_prot_range dut (.clk(clk), .rst_n(rst_n), .cap_supported(cap), .cmd_lock(lk),
    .cmd_unlock(ulk), .reg_wr(wr), .reg_sel(sel), .reg_wdata(wdata), .reg_rdata(rdata),
    .req_valid_in(rv), .req_addr(addr), .resp_valid(resp_valid), .resp_blocked(resp_blocked));

  function automatic logic exp_block(logic [63:0] a);
    logic [35:0] lo, hi, x;
    lo = {m_base, 21'h0};
    hi = {m_lim, 21'h1FFFFF};
    x  = a[35:0];
    return m_en && (m_lim >= m_base) && x >= lo && x <= hi;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] s, logic [63:0] d);
    @(negedge clk); wr = 1; sel = s; wdata = d;
    if (s == 2) m_en = d[0];
    else if (cap && !m_lock && !m_en) begin
      if (s == 0) m_base = d[35:21]; else m_lim = d[35:21];
    end
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(string req, logic [1:0] s, logic [63:0] exp);
    @(negedge clk); sel = s; #1; check(req, rdata, exp);
  endtask

  task automatic cmd(logic l, logic u);
    @(negedge clk); lk = l; ulk = u;
    if (l) m_lock = 1; else if (u) m_lock = 0;
    @(negedge clk); lk = 0; ulk = 0;
  endtask

  task automatic req(string r, logic [63:0] a);
    @(negedge clk); rv = 1; addr = a;
    @(negedge clk); rv = 0;
    check({r, " valid"}, {63'd0, resp_valid}, 64'd1);
    check(r, {63'd0, resp_blocked}, {63'd0, exp_block(a)});
    @(negedge clk);
    check({r, " hold"}, {62'd0, resp_valid, resp_blocked}, {62'd0, 1'b0, exp_block(a)});
  endtask

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rreg("R1 base", 0, 0); rreg("R1 limit", 1, 0); rreg("R1 ctrl", 2, 0);
    req("R1 no block", 64'h0);
    wreg(1, '1); rreg("R2 limit ones", 1, 64'h0000_000F_FFE0_0000);
    wreg(0, '1); rreg("R2 base ones", 0, 64'h0000_000F_FFE0_0000);
    wreg(0, 64'h0000_0002_0000_0000); wreg(1, 64'h0000_0002_0040_1234);
    rreg("R2 limit", 1, 64'h0000_0002_0040_0000);
    wreg(2, 1);
    req("R7 base edge", 64'h2_0000_0000);
    req("R7 below base", 64'h1_FFFF_FFFF);
    req("R7 limit top", 64'h2_005F_FFFF);
    req("R7 past limit", 64'h2_0060_0000);
    req("R9 upper bits", 64'hABCD_0002_0010_0000);
    wreg(1, 64'h1_0000_0000); rreg("R6 write ignored", 1, 64'h2_0040_0000);
    wreg(2, 0); cmd(1, 0);
    wreg(1, 64'h1_0000_0000); rreg("R3 locked", 1, 64'h2_0040_0000);
    cmd(1, 1); wreg(0, 0); rreg("R4 lock wins", 0, 64'h2_0000_0000);
    cmd(0, 1); wreg(1, 64'h1_0000_0000); rreg("R3 unlocked", 1, 64'h1_0000_0000);
    wreg(2, 1); req("R8 inverted", 64'h2_0000_0000); req("R8 inverted lo", 64'h1_0000_0000);
    wreg(2, 0); cap = 0; wreg(0, 64'h3_0000_0000); rreg("R5 nocap", 0, 64'h2_0000_0000);
    cap = 1;
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: cmd(1'($urandom), 1'($urandom));
        1: wreg(2'($urandom_range(0, 2)), {$urandom, $urandom});
        2: wreg(2, 64'($urandom_range(0, 1)));
        3: req("R7 random", {$urandom, $urandom});
        4: req("R9 random", {$urandom, 4'h0, m_base, 21'($urandom)});
        default: begin
          rreg("R2 random base", 0, {28'd0, m_base, 21'd0});
          rreg("R2 random limit", 1, {28'd0, m_lim, 21'd0});
        end
      endcase
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule